// File: doc/BRIEF.md
# SHA-256 Message Schedule Update Unit

This unit produces four fresh SHA-256 message schedule words per accepted operation. It offers two sub-operations, picked by a one-bit operation select. The sigma0 step takes the destination's current four words and one source vector. It applies the small sigma0 function to a window shifted by one word, then adds the destination words. The sigma1 step takes three vectors. It applies small sigma1 and adds both the destination words and a shifted window of the other two operands. Its two upper result words use the two lower result words from the same operation as their sigma1 inputs. Round compression and the addition of round constants are handled elsewhere.

Operands arrive on a valid/ready stream and the result leaves on a valid/ready stream held in one output register. An input beat is accepted when `in_valid && in_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new operand is taken. A synchronous active-high reset empties the output register.

Top module: `msg_sched_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_data` are cleared to zero at that edge.
- R2: With `in_op` = 0 (sigma0 step), let W = {op2[31:0], op1[127:32]}. Result word k (bits 32k+31:32k, k = 0..3) is sigma0(W word k) + op1 word k. Here sigma0(x) = rotr(x,7) ^ rotr(x,18) ^ (x >> 3).
- R3: With `in_op` = 0, the value on `in_op3` has no effect on the result.
- R4: With `in_op` = 1 (sigma1 step), let V = {op3[31:0], op2[127:32]}. Result words 0 and 1 are sigma1(op3 word k+2) + op1 word k + V word k. Here sigma1(x) = rotr(x,17) ^ rotr(x,19) ^ (x >> 10).
- R5: With `in_op` = 1, result words 2 and 3 are sigma1(result word k-2) + op1 word k + V word k. The result words used are those produced by the same operation.
- R6: All word additions wrap modulo 2^32, and the right shifts inside sigma0 and sigma1 fill with zeros.
- R7: An accepted beat shows its result on `out_data` with `out_valid` high at the next clock edge. Beats accepted on consecutive cycles give results on consecutive cycles.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` holds its value.
- R9: When the result is taken (`out_valid && out_ready`) and no beat is offered, `out_valid` is low after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_op | input | 1 | 0 = sigma0 step, 1 = sigma1 step |
| in_op1 | input | 128 | Destination's current words (word 0 in bits 31:0) |
| in_op2 | input | 128 | First source vector |
| in_op3 | input | 128 | Second source vector, used only by the sigma1 step |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Four new schedule words (word 0 in bits 31:0) |

## Verification
The hardest case to reach from the ports is a sigma1 step whose two upper words would be wrong if they took their sigma1 input from an operand instead of from the lower result words. With random operands such a wiring slip can look plausible. The stimulus therefore uses operands where every input feeding the upper words is zero except the chain from the lower words. That way the upper words are non-zero only if the dependency is honoured. A stall is also forced with a second beat waiting, to show that the held result and the refused beat both survive.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = 4;
  localparam int unsigned VEC_W  = WORD_W * LANES;
  localparam int unsigned HALF   = LANES / 2;

  // rotation and shift amounts of the two small sigma functions
  localparam int unsigned S0_ROT_A = 7;
  localparam int unsigned S0_ROT_B = 18;
  localparam int unsigned S0_SHR   = 3;
  localparam int unsigned S1_ROT_A = 17;
  localparam int unsigned S1_ROT_B = 19;
  localparam int unsigned S1_SHR   = 10;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [VEC_W-1:0]  vec_t;

  typedef enum logic {
    OP_SIG0_STEP = 1'b0,
    OP_SIG1_STEP = 1'b1
  } sched_op_e;

  function automatic word_t rotr(word_t x, int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t small_sig0(word_t x);
    return rotr(x, S0_ROT_A) ^ rotr(x, S0_ROT_B) ^ (x >> S0_SHR);
  endfunction

  function automatic word_t small_sig1(word_t x);
    return rotr(x, S1_ROT_A) ^ rotr(x, S1_ROT_B) ^ (x >> S1_SHR);
  endfunction
endpackage

// File: rtl/sched_lane.sv
module sched_lane
  import sched_pkg::*;
#(
  parameter bit USE_SIG1 = 1'b0
) (
  input  word_t sig_in,
  input  word_t add_a,
  input  word_t add_b,
  output word_t sum
);
  word_t mixed;

  generate
    if (USE_SIG1) begin : g_sig1
      always_comb mixed = small_sig1(sig_in);
    end else begin : g_sig0
      always_comb mixed = small_sig0(sig_in);
    end
  endgenerate

  // modulo 2^WORD_W by width truncation
  assign sum = mixed + add_a + add_b;
endmodule

// File: rtl/sched_sig0_step.sv
module sched_sig0_step
  import sched_pkg::*;
(
  input  vec_t  dst,
  input  word_t src_lo,
  output vec_t  res
);
  vec_t win;
  assign win = {src_lo, dst[VEC_W-1:WORD_W]};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sched_lane #(.USE_SIG1(1'b0)) u_lane (
      .sig_in (win[g*WORD_W +: WORD_W]),
      .add_a  (dst[g*WORD_W +: WORD_W]),
      .add_b  ('0),
      .sum    (res[g*WORD_W +: WORD_W])
    );
  end
endmodule

// File: rtl/sched_sig1_step.sv
module sched_sig1_step
  import sched_pkg::*;
(
  input  vec_t                     dst,
  input  logic [VEC_W-WORD_W-1:0]  src_a_hi,
  input  word_t                    src_b_lo,
  input  logic [HALF*WORD_W-1:0]   src_b_hi,
  output vec_t                     res
);
  localparam int unsigned HALF_W = HALF * WORD_W;

  vec_t              win;
  logic [HALF_W-1:0] lo_res;
  logic [HALF_W-1:0] hi_res;

  assign win = {src_b_lo, src_a_hi};

  // lower half: sigma1 input from the upper words of the second source
  for (genvar g = 0; g < HALF; g++) begin : g_lo
    sched_lane #(.USE_SIG1(1'b1)) u_lane (
      .sig_in (src_b_hi[g*WORD_W +: WORD_W]),
      .add_a  (dst[g*WORD_W +: WORD_W]),
      .add_b  (win[g*WORD_W +: WORD_W]),
      .sum    (lo_res[g*WORD_W +: WORD_W])
    );
  end

  // upper half: sigma1 input chained from the lower half of this result
  for (genvar g = 0; g < HALF; g++) begin : g_hi
    sched_lane #(.USE_SIG1(1'b1)) u_lane (
      .sig_in (lo_res[g*WORD_W +: WORD_W]),
      .add_a  (dst[HALF_W + g*WORD_W +: WORD_W]),
      .add_b  (win[HALF_W + g*WORD_W +: WORD_W]),
      .sum    (hi_res[g*WORD_W +: WORD_W])
    );
  end

  assign res = {hi_res, lo_res};
endmodule

// File: rtl/msg_sched_unit.sv
module msg_sched_unit
  import sched_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_op,
  input  logic [VEC_W-1:0]  in_op1,
  input  logic [VEC_W-1:0]  in_op2,
  input  logic [VEC_W-1:0]  in_op3,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_data
);
  localparam int unsigned HALF_W = HALF * WORD_W;

  vec_t      sig0_res;
  vec_t      sig1_res;
  vec_t      next_res;
  sched_op_e op_sel;
  logic      unused_op3_mid;

  // word 1 of the second source feeds neither step
  assign unused_op3_mid = ^in_op3[2*WORD_W-1:WORD_W];
  assign op_sel = sched_op_e'(in_op);

  sched_sig0_step u_sig0 (
    .dst    (in_op1),
    .src_lo (in_op2[WORD_W-1:0]),
    .res    (sig0_res)
  );

  sched_sig1_step u_sig1 (
    .dst      (in_op1),
    .src_a_hi (in_op2[VEC_W-1:WORD_W]),
    .src_b_lo (in_op3[WORD_W-1:0]),
    .src_b_hi (in_op3[VEC_W-1:VEC_W-HALF_W]),
    .res      (sig1_res)
  );

  always_comb begin
    unique case (op_sel)
      OP_SIG1_STEP: next_res = sig1_res;
      default:      next_res = sig0_res;
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_res;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0)) else $error("reset clear"); // R1
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid) else $error("latency"); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("stall hold"); // R8
  AST_STALL_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready) else $error("stall refuse"); // R8
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid) else $error("drain"); // R9
endmodule

// File: tb/msg_sched_unit_tb.sv
module msg_sched_unit_tb;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic         op;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] c;
  } stim_t;

  localparam int NVEC = 7;
  localparam stim_t VECS [NVEC] = '{
    '{1'b0, 128'h0, 128'h0, 128'h0},
    '{1'b0, 128'h00000003_00000002_80000000_FFFFFFFF, 128'h12345678_9ABCDEF0_0F1E2D3C_4B5A6978, 128'hDEADBEEF_0BADF00D_CAFEBABE_8BADF00D},
    '{1'b0, 128'h55555555_AAAAAAAA_55555555_AAAAAAAA, 128'h0, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF},
    '{1'b1, 128'h0, 128'h0, 128'h0},
    '{1'b1, 128'h6A09E667_BB67AE85_3C6EF372_A54FF53A, 128'h510E527F_9B05688C_1F83D9AB_5BE0CD19, 128'h428A2F98_71374491_B5C0FBCF_E9B5DBA5},
    '{1'b1, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF},
    '{1'b0, 128'h80000000_00000001_7FFFFFFF_FFFFFFFE, 128'h00000000_00000000_00000000_80000000, 128'h0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_op = 1'b0;
  logic [127:0] in_op1 = '0;
  logic [127:0] in_op2 = '0;
  logic [127:0] in_op3 = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  msg_sched_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_op1(in_op1), .in_op2(in_op2), .in_op3(in_op3),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] rr(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic logic [31:0] m_s0(logic [31:0] x);
    return rr(x, 7) ^ rr(x, 18) ^ (x >> 3);
  endfunction
  function automatic logic [31:0] m_s1(logic [31:0] x);
    return rr(x, 17) ^ rr(x, 19) ^ (x >> 10);
  endfunction

  function automatic logic [127:0] model(logic op, logic [127:0] a, logic [127:0] b, logic [127:0] c);
    logic [31:0] t [4];
    logic [31:0] r [4];
    if (!op) begin
      t[0] = a[63:32]; t[1] = a[95:64]; t[2] = a[127:96]; t[3] = b[31:0];
      for (int i = 0; i < 4; i++) r[i] = m_s0(t[i]) + a[i*32 +: 32];
    end else begin
      t[0] = b[63:32]; t[1] = b[95:64]; t[2] = b[127:96]; t[3] = c[31:0];
      r[0] = m_s1(c[95:64])  + a[31:0]   + t[0];
      r[1] = m_s1(c[127:96]) + a[63:32]  + t[1];
      r[2] = m_s1(r[0])      + a[95:64]  + t[2];
      r[3] = m_s1(r[1])      + a[127:96] + t[3];
    end
    return {r[3], r[2], r[1], r[0]};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one beat with the consumer ready; sampled 1 time unit after the capture edge
  task automatic one_op(logic op, logic [127:0] a, logic [127:0] b, logic [127:0] c, output logic [127:0] res);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_op1 = a; in_op2 = b; in_op3 = c;
    @(posedge clk); #1;
    res = out_data;
    chk("R7 valid", {127'b0, out_valid}, 128'd1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] r_a, r_b;
    repeat (3) @(posedge clk); #1;
    chk("R1 reset valid", {127'b0, out_valid}, 128'd0);
    chk("R1 reset data", out_data, 128'd0);
    @(negedge clk); rst = 1'b0;

    // streamed table, one beat per cycle (R2, R4, R6, R7)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_op = VECS[i].op;
      in_op1 = VECS[i].a; in_op2 = VECS[i].b; in_op3 = VECS[i].c;
      @(posedge clk); #1;
      chk("R7 stream valid", {127'b0, out_valid}, 128'd1);
      chk(VECS[i].op ? "R4 sigma1 step" : "R2 sigma0 step", out_data,
          model(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].c));
    end
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R9 drained", {127'b0, out_valid}, 128'd0);

    // R2 hand value: window word 3 = 1 gives sigma0(1) in word 3
    one_op(1'b0, 128'h0, 128'h1, 128'h0, r_a);
    chk("R2 hand", r_a, 128'h02004000_00000000_00000000_00000000);

    // R6 wrap and zero-fill shift: sigma0(0x80000000)=0x11002000, +0xFFFFFFFF
    one_op(1'b0, 128'h00000000_00000000_80000000_FFFFFFFF, 128'h0, 128'h0, r_a);
    chk("R6 wrap", r_a, 128'h00000000_00000000_80000000_11001FFF);

    // R3: second source ignored in sigma0 step
    one_op(1'b0, VECS[1].a, VECS[1].b, 128'h0, r_a);
    one_op(1'b0, VECS[1].a, VECS[1].b, {4{32'hFFFFFFFF}}, r_b);
    chk("R3 op3 ignored", r_b, r_a);
    chk("R3 op3 value", r_b, model(1'b0, VECS[1].a, VECS[1].b, 128'h0));

    // R5: upper words non-zero only through the lower result words
    one_op(1'b1, 128'h0, 128'h0, 128'h00000001_00000001_00000000_00000000, r_a);
    chk("R5 chained upper words", r_a, 128'h44000028_44000028_0000A000_0000A000);

    // R8 stall: hold result, refuse the waiting beat, then take it
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 1'b1; in_op1 = VECS[4].a; in_op2 = VECS[4].b; in_op3 = VECS[4].c;
    @(posedge clk); #1;
    r_a = out_data;
    chk("R8 first result", r_a, model(1'b1, VECS[4].a, VECS[4].b, VECS[4].c));
    @(negedge clk);
    in_op = 1'b0; in_op1 = VECS[1].a; in_op2 = VECS[1].b; in_op3 = VECS[1].c;
    #1;
    chk("R8 in_ready low", {127'b0, in_ready}, 128'd0);
    repeat (2) @(posedge clk); #1;
    chk("R8 held data", out_data, r_a);
    chk("R8 held valid", {127'b0, out_valid}, 128'd1);
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #1;
    chk("R8 waiting beat taken", out_data, model(1'b0, VECS[1].a, VECS[1].b, VECS[1].c));
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R9 empty after take", {127'b0, out_valid}, 128'd0);

    // R1 mid-run reset with a full output register
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1 midrun valid", {127'b0, out_valid}, 128'd0);
    chk("R1 midrun data", out_data, 128'd0);
    @(negedge clk); rst = 1'b0; out_ready = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule